// File: doc/BRIEF.md
# Streaming Pixel Point-Operation Unit

This block processes an 8-bit grayscale pixel stream one pixel per clock. Each valid input pixel arrives together with an operand value, a threshold and a 2-bit operation code, and the block applies one of four point operations to it: saturating addition of the operand, saturating subtraction of the operand, binarization against the threshold, or inversion. The result is held in a register and leaves the block with a valid strobe.

A second, optional stage compares the processed pixel with a reference pixel that travels alongside it in the same input beat. When the two are equal the output is forced to black (0); otherwise the processed pixel passes through unchanged. This lets a thresholded copy of an image pick out, and blank, the pixels that match it.

The output side carries the column and line of each outgoing pixel within a frame of configurable size (256 by 382 by default), with a start-of-frame flag on the first pixel and an end-of-frame flag on the last.

Top module: `pix_point_unit`

## Requirements
- R1: Operation code 00 outputs pixel plus operand; a sum above 255 is clamped to 255.
- R2: Operation code 01 outputs pixel minus operand; a result below 0 is clamped to 0.
- R3: Operation code 10 outputs 255 when the pixel is strictly greater than the threshold and 0 otherwise, so a pixel equal to the threshold gives 0.
- R4: Operation code 11 outputs 255 minus the pixel (the bitwise complement).
- R5: With the masking stage enabled (MASK_EN=1), an operation result equal to the reference pixel of the same beat is output as 0; any other result is output unchanged.
- R6: out_valid rises exactly 2 cycles after an accepted in_valid when MASK_EN=1 (1 cycle when MASK_EN=0), and out_pixel carries that beat's result in the same cycle; back-to-back input beats give back-to-back outputs.
- R7: out_col and out_line give the position of the pixel on the output; after each valid output the column advances, wrapping from FRAME_W-1 to 0 with the line advancing, and the line wraps from FRAME_H-1 to 0.
- R8: out_sof is high exactly with the valid output pixel at column 0, line 0; out_eof is high exactly with the valid output pixel at column FRAME_W-1, line FRAME_H-1.
- R9: A synchronous active-high reset clears out_valid, out_pixel and the position to column 0, line 0, and discards beats offered while it is high.
- R10: Operation code, operand, threshold, pixel and reference are taken only on cycles with in_valid high; while in_valid is low out_valid stays low after the pipeline drains and out_pixel keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| in_pixel | input | PIX_W | Input pixel |
| in_ref | input | PIX_W | Reference pixel for the masking stage |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 binarize, 11 invert |
| op_value | input | PIX_W | Operand for add and subtract |
| op_thresh | input | PIX_W | Threshold for binarize |
| out_valid | output | 1 | Output beat qualifier |
| out_pixel | output | PIX_W | Processed pixel |
| out_col | output | COL_W | Column of the output pixel |
| out_line | output | LINE_W | Line of the output pixel |
| out_sof | output | 1 | First pixel of a frame |
| out_eof | output | 1 | Last pixel of a frame |

## Verification
The bench builds the unit with PIX_W=8, MASK_EN=1 and a 4 by 3 frame. The 8-bit width keeps the clamping points at 0 and 255 where directed operands push straight past them, and the masking stage with its two-cycle latency is in the path for every result. The tiny frame brings column wrap, line wrap, end of frame and the return to start of frame within thirteen pixels, which the full 256 by 382 frame would put tens of thousands of cycles away.

// File: rtl/ppu_pkg.sv
package ppu_pkg;

    // Operation codes carried on op_sel
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_BIN = 2'b10,
        OP_INV = 2'b11
    } op_e;

endpackage

// File: rtl/ppu_point_op.sv
module ppu_point_op #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pixel,
    input  logic [PIX_W-1:0] in_ref,
    input  logic [1:0]       op_sel,
    input  logic [PIX_W-1:0] op_value,
    input  logic [PIX_W-1:0] op_thresh,
    output logic             s1_valid,
    output logic [PIX_W-1:0] s1_pixel,
    output logic [PIX_W-1:0] s1_ref
);
    import ppu_pkg::*;

    localparam int EXT_W = PIX_W + 1;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pixel;
        logic [PIX_W-1:0] refp;
    } st_t;

    st_t st_d, st_q;
    logic [EXT_W-1:0] sum_w, diff_w;
    logic [PIX_W-1:0] res_w;

    always_comb begin
        sum_w  = {1'b0, in_pixel} + {1'b0, op_value};
        diff_w = {1'b0, in_pixel} - {1'b0, op_value};
        unique case (op_e'(op_sel))
            OP_ADD:  res_w = sum_w[PIX_W] ? '1 : sum_w[PIX_W-1:0];
            OP_SUB:  res_w = diff_w[PIX_W] ? '0 : diff_w[PIX_W-1:0];
            OP_BIN:  res_w = (in_pixel > op_thresh) ? '1 : '0;
            default: res_w = ~in_pixel;
        endcase

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.pixel = res_w;
            st_d.refp  = in_ref;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign s1_valid = st_q.valid;
    assign s1_pixel = st_q.pixel;
    assign s1_ref   = st_q.refp;
endmodule

// File: rtl/ppu_mask_stage.sv
module ppu_mask_stage #(
    parameter int PIX_W   = 8,
    parameter bit MASK_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s1_valid,
    input  logic [PIX_W-1:0] s1_pixel,
    input  logic [PIX_W-1:0] s1_ref,
    output logic             s2_valid,
    output logic [PIX_W-1:0] s2_pixel
);
    generate
        if (MASK_EN) begin : g_mask
            typedef struct packed {
                logic             valid;
                logic [PIX_W-1:0] pixel;
            } st_t;

            st_t st_d, st_q;

            always_comb begin
                st_d       = st_q;
                st_d.valid = s1_valid;
                if (s1_valid)
                    st_d.pixel = (s1_pixel == s1_ref) ? '0 : s1_pixel;
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_d;
            end

            assign s2_valid = st_q.valid;
            assign s2_pixel = st_q.pixel;
        end else begin : g_bypass
            assign s2_valid = s1_valid;
            assign s2_pixel = s1_pixel;
        end
    endgenerate
endmodule

// File: rtl/ppu_frame_pos.sv
module ppu_frame_pos #(
    parameter int FRAME_W = 256,
    parameter int FRAME_H = 382,
    parameter int COL_W   = 8,
    parameter int LINE_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    output logic [COL_W-1:0]  col,
    output logic [LINE_W-1:0] line,
    output logic              sof,
    output logic              eof
);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(FRAME_W - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_H - 1);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pix_valid) begin
            if (st_q.col == COL_LAST) begin
                st_d.col  = '0;
                st_d.line = (st_q.line == LINE_LAST) ? '0 : st_q.line + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign col  = st_q.col;
    assign line = st_q.line;
    assign sof  = pix_valid && (st_q.col == '0) && (st_q.line == '0);
    assign eof  = pix_valid && (st_q.col == COL_LAST) && (st_q.line == LINE_LAST);
endmodule

// File: rtl/pix_point_unit.sv
module pix_point_unit #(
    parameter int PIX_W   = 8,
    parameter int FRAME_W = 256,
    parameter int FRAME_H = 382,
    parameter bit MASK_EN = 1'b1,
    localparam int COL_W  = (FRAME_W > 1) ? $clog2(FRAME_W) : 1,
    localparam int LINE_W = (FRAME_H > 1) ? $clog2(FRAME_H) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic [PIX_W-1:0]  in_ref,
    input  logic [1:0]        op_sel,
    input  logic [PIX_W-1:0]  op_value,
    input  logic [PIX_W-1:0]  op_thresh,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    output logic [COL_W-1:0]  out_col,
    output logic [LINE_W-1:0] out_line,
    output logic              out_sof,
    output logic              out_eof
);
    logic             s1_valid;
    logic [PIX_W-1:0] s1_pixel;
    logic [PIX_W-1:0] s1_ref;

    ppu_point_op #(.PIX_W(PIX_W)) u_op (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_pixel  (in_pixel),
        .in_ref    (in_ref),
        .op_sel    (op_sel),
        .op_value  (op_value),
        .op_thresh (op_thresh),
        .s1_valid  (s1_valid),
        .s1_pixel  (s1_pixel),
        .s1_ref    (s1_ref)
    );

    ppu_mask_stage #(.PIX_W(PIX_W), .MASK_EN(MASK_EN)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_pixel (s1_pixel),
        .s1_ref   (s1_ref),
        .s2_valid (out_valid),
        .s2_pixel (out_pixel)
    );

    ppu_frame_pos #(
        .FRAME_W (FRAME_W),
        .FRAME_H (FRAME_H),
        .COL_W   (COL_W),
        .LINE_W  (LINE_W)
    ) u_pos (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (out_valid),
        .col       (out_col),
        .line      (out_line),
        .sof       (out_sof),
        .eof       (out_eof)
    );
endmodule

// File: rtl/ppu_checker.sv
module ppu_checker #(
    parameter int PIX_W   = 8,
    parameter int FRAME_W = 256,
    parameter int FRAME_H = 382,
    parameter bit MASK_EN = 1'b1,
    parameter int COL_W   = 8,
    parameter int LINE_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PIX_W-1:0]  in_pixel,
    input logic [PIX_W-1:0]  in_ref,
    input logic [1:0]        op_sel,
    input logic [PIX_W-1:0]  op_value,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_pixel,
    input logic [COL_W-1:0]  out_col,
    input logic [LINE_W-1:0] out_line
);
    localparam int LAT = MASK_EN ? 2 : 1;
    localparam logic [PIX_W-1:0] MAXV = '1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);

    AST_ADD_CLAMP: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_sel, LAT) == 2'b00 &&
        ({1'b0, $past(in_pixel, LAT)} + {1'b0, $past(op_value, LAT)}) > {1'b0, MAXV}
        |-> out_pixel == MAXV || out_pixel == '0); // R1

    AST_SUB_CLAMP: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_sel, LAT) == 2'b01 &&
        $past(op_value, LAT) > $past(in_pixel, LAT)
        |-> out_pixel == '0); // R2

    AST_BIN_LEVELS: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_sel, LAT) == 2'b10
        |-> out_pixel == '0 || out_pixel == MAXV); // R3

    AST_INV_VALUE: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_sel, LAT) == 2'b11
        |-> out_pixel == ~$past(in_pixel, LAT) || out_pixel == '0); // R4

    generate
        if (MASK_EN) begin : g_mask_chk
            AST_MASK_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
                out_valid && out_pixel != '0
                |-> out_pixel != $past(in_ref, LAT)); // R5
        end
    endgenerate

    AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LAT)); // R6

    AST_VALID_ARRIVES: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid, LAT) && !$past(rst, LAT) && !$past(rst, 1)
        |-> out_valid); // R6

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(out_valid) && $past(out_col) != COL_LAST
        |-> out_col == $past(out_col) + 1'b1); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && out_pixel == '0 &&
                       out_col == '0 && out_line == '0); // R9
endmodule

bind pix_point_unit ppu_checker #(
    .PIX_W   (PIX_W),
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H),
    .MASK_EN (MASK_EN),
    .COL_W   (COL_W),
    .LINE_W  (LINE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_pixel  (in_pixel),
    .in_ref    (in_ref),
    .op_sel    (op_sel),
    .op_value  (op_value),
    .out_valid (out_valid),
    .out_pixel (out_pixel),
    .out_col   (out_col),
    .out_line  (out_line)
);

// File: tb/sim_pix_point_unit.sv
`timescale 1ns/1ps
module sim_pix_point_unit;
    localparam int PW = 8;
    localparam int FW = 4;
    localparam int FH = 3;
    localparam int CW = 2;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_pixel = '0;
    logic [PW-1:0] in_ref = '0;
    logic [1:0]    op_sel = '0;
    logic [PW-1:0] op_value = '0;
    logic [PW-1:0] op_thresh = '0;
    logic          out_valid;
    logic [PW-1:0] out_pixel;
    logic [CW-1:0] out_col;
    logic [LW-1:0] out_line;
    logic          out_sof;
    logic          out_eof;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pix_point_unit #(.PIX_W(PW), .FRAME_W(FW), .FRAME_H(FH), .MASK_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel),
        .in_ref(in_ref), .op_sel(op_sel), .op_value(op_value),
        .op_thresh(op_thresh), .out_valid(out_valid), .out_pixel(out_pixel),
        .out_col(out_col), .out_line(out_line), .out_sof(out_sof),
        .out_eof(out_eof)
    );

    // Expected value from the requirement text
    function automatic logic [7:0] model(input logic [1:0] sel, input int v,
                                         input int th, input int p, input int r);
        int res;
        case (sel)
            2'b00:   res = (p + v > 255) ? 255 : p + v;
            2'b01:   res = (p - v < 0) ? 0 : p - v;
            2'b10:   res = (p > th) ? 255 : 0;
            default: res = 255 - p;
        endcase
        if (res == r) res = 0;
        return 8'(res);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one beat, sample its result two cycles later
    task automatic one(input logic [1:0] sel, input int v, input int th,
                       input int p, input int r, output int got, output int gv);
        @(negedge clk);
        in_valid = 1'b1; op_sel = sel; op_value = 8'(v); op_thresh = 8'(th);
        in_pixel = 8'(p); in_ref = 8'(r);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        got = int'(out_pixel); gv = int'(out_valid);
    endtask

    task automatic op_check(input string tag, input logic [1:0] sel, input int v,
                            input int th, input int p, input int r);
        int got, gv;
        one(sel, v, th, p, r, got, gv);
        chk({tag, " valid"}, gv, 1);
        chk(tag, got, int'(model(sel, v, th, p, r)));
    endtask

    task automatic t_add;
        op_check("R1 add plain", 2'b00, 20, 0, 100, 0);
        op_check("R1 add clamp", 2'b00, 60, 0, 200, 0);
        op_check("R1 add exact 255", 2'b00, 55, 0, 200, 0);
    endtask

    task automatic t_sub;
        op_check("R2 sub plain", 2'b01, 30, 0, 100, 1);
        op_check("R2 sub clamp", 2'b01, 90, 0, 40, 1);
        op_check("R2 sub exact 0", 2'b01, 40, 0, 40, 1);
    endtask

    task automatic t_bin;
        op_check("R3 bin above", 2'b10, 0, 128, 129, 1);
        op_check("R3 bin equal", 2'b10, 0, 128, 128, 1);
        op_check("R3 bin below", 2'b10, 0, 128, 3, 1);
    endtask

    task automatic t_inv;
        op_check("R4 inv 0", 2'b11, 0, 0, 0, 1);
        op_check("R4 inv 0x5A", 2'b11, 0, 0, 8'h5A, 1);
    endtask

    task automatic t_mask;
        int got, gv;
        one(2'b00, 5, 0, 10, 15, got, gv);
        chk("R5 match blacked", got, 0);
        one(2'b00, 5, 0, 10, 16, got, gv);
        chk("R5 differ passes", got, 15);
        one(2'b11, 0, 0, 0, 255, got, gv);
        chk("R5 inverted match blacked", got, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_pixel = 8'd77; op_sel = 2'b00;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk("R9 reset valid", int'(out_valid), 0);
        chk("R9 reset pixel", int'(out_pixel), 0);
        chk("R9 reset col", int'(out_col), 0);
        chk("R9 reset line", int'(out_line), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R9 beat during reset dropped", int'(out_valid), 0);
    endtask

    task automatic t_stream;
        logic [1:0] s [6] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b10};
        int         p [6] = '{250, 7, 200, 17, 1, 9};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 1) chk("R6 not early", int'(out_valid), 0);
            if (i >= 2) begin
                chk("R6 stream valid", int'(out_valid), 1);
                chk("R6 stream data", int'(out_pixel),
                    int'(model(s[i-2], 10, 100, p[i-2], 300)));
            end
            if (i < 6) begin
                in_valid = 1'b1; op_sel = s[i]; op_value = 8'd10;
                op_thresh = 8'd100; in_pixel = 8'(p[i]); in_ref = 8'd0;
                if (p[i] == 17) in_ref = 8'd1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R6 drained", int'(out_valid), 0);
    endtask

    task automatic t_hold;
        int got, gv;
        one(2'b01, 3, 0, 50, 0, got, gv);
        chk("R10 first result", got, 47);
        op_sel = 2'b11; op_value = 8'd99; op_thresh = 8'd1; in_pixel = 8'd200;
        in_ref = 8'd47;
        @(negedge clk);
        @(negedge clk);
        chk("R10 no valid on idle", int'(out_valid), 0);
        chk("R10 pixel held", int'(out_pixel), 47);
    endtask

    task automatic t_frame;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int k = (i - 2) % (FW * FH);
                chk("R7 frame valid", int'(out_valid), 1);
                chk("R7 col", int'(out_col), k % FW);
                chk("R7 line", int'(out_line), k / FW);
                chk("R8 sof", int'(out_sof), int'(k == 0));
                chk("R8 eof", int'(out_eof), int'(k == FW * FH - 1));
            end
            in_valid = (i < 13);
            op_sel = 2'b11; in_pixel = 8'(i); in_ref = 8'd0;
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 no sof when idle", int'(out_sof), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_add();
        t_reset();
        t_sub();
        t_bin();
        t_inv();
        t_mask();
        t_stream();
        t_hold();
        t_frame();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule